// File: doc/BRIEF.md
# MSI Capability and Message Generator

This block is the device side of message-signalled interrupts. It holds the capability structure that software finds by walking configuration space: the header dword with the capability identifier and the link to the next capability, the control field, the target address (a low dword and, in the wide build, a high dword), the 16-bit data pattern and a per-vector mask. Software reads and writes these dwords through a simple register port. Reads return data one cycle after the strobe.

Each interrupt source is a level that the block watches for rising edges. A rising edge marks the source as pending. When messages are enabled and the source's mask bit is clear, the pending source with the lowest index is turned into a single posted write on a valid/ready message port. Its address is the programmed address. Its data is the programmed pattern with the low N bits replaced by the source index, where 2^N is the number of vectors software granted. A masked or disabled source stays pending and is sent once it is unmasked or enabled. Repeated edges while a source is already pending merge into one message.

Top module: `msi_msg_gen`

## Requirements
- R1: A read of dword 0 returns the capability ID 0x05 in bits 7:0, the NEXT_PTR parameter in bits 15:8 and the control field in bits 31:16. In the control field, bit 0 is enable, bits 3:1 are the read-only log2 vectors-capable value (MMC), bits 6:4 are the granted log2 vector count (MME), bit 7 is the read-only wide-address flag and bits 15:8 read zero. Read data appears on the clock edge that samples the read strobe.
- R2: A write to dword 0 changes only enable and MME. An MME value above MMC is stored as MMC.
- R3: Dword 1 holds the low address, and its bits 1:0 always read zero. In the wide build (ADDR64=1, the default) dword 2 holds the high address and dword 3 the data. Otherwise dword 2 holds the data. The data dword returns the 16-bit pattern in bits 15:0, with bits 31:16 reading zero.
- R4: Dword 4 is the mask, one bit per source. Bits at NUM_SRC and above read zero.
- R5: A rising edge on irq_req[i] while enabled and unmasked produces exactly one message. Its address is {high, low}, and its data is the pattern with bits MME-1:0 replaced by the low MME bits of i.
- R6: A request that arrives while its mask bit is set, or while enable is 0, is held pending and produces no message. It is sent once the mask bit clears and enable is 1.
- R7: Several rising edges on a source while it is pending produce a single message.
- R8: When several sources are sendable, messages leave in ascending source index.
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold.
- R10: After reset msg_valid is low, enable and MME are 0, and address, data and mask read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Dword index within the capability |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| irq_req | input | NUM_SRC | Interrupt source levels, rising edge requests |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 16 | Message write data |

## Verification
A corrupted pending bit shows up at the message port within two cycles. It appears either as a message that no request caused or as a request that never produces one, and the scoreboard catches the extra or missing write when the port drains. A wrong control or mask state appears on the next read of that dword. Its effect on sending shows up as a message that arrives while it should be blocked, or with the wrong low data bits. A wrong priority order or a message that changes while stalled mismatches at the very handshake where it happens.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] CAP_ID   = 8'h05;
  localparam logic [2:0] DW_HDR   = 3'd0;
  localparam logic [2:0] DW_ALO   = 3'd1;
  localparam logic [2:0] DW_TWO   = 3'd2;
  localparam logic [2:0] DW_THREE = 3'd3;
  localparam logic [2:0] DW_MASK  = 3'd4;

  typedef struct packed {
    logic [63:0] addr;
    logic [15:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int         NUM_SRC  = 8,
  parameter int         MMC      = 3,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               en,
  output logic [2:0]         mme,
  output logic [63:0]        base_addr,
  output logic [15:0]        base_data,
  output logic [NUM_SRC-1:0] mask
);
  localparam logic [2:0] MMC_W = 3'(MMC);

  logic               en_q;
  logic [2:0]         mme_q;
  logic [31:2]        alo_q;
  logic [31:0]        ahi_q;
  logic [15:0]        dat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [2:0]         mme_wr;
  logic [15:0]        ctrl;
  logic [31:0]        rd_mux;

  // grant cannot exceed capability
  assign mme_wr = (cfg_wdata[22:20] > MMC_W) ? MMC_W : cfg_wdata[22:20];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mme_q  <= 3'd0;
      alo_q  <= '0;
      ahi_q  <= '0;
      dat_q  <= '0;
      mask_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        DW_HDR: begin
          en_q  <= cfg_wdata[16];
          mme_q <= mme_wr;
        end
        DW_ALO:  alo_q <= cfg_wdata[31:2];
        DW_TWO: begin
          if (ADDR64) ahi_q <= cfg_wdata;
          else        dat_q <= cfg_wdata[15:0];
        end
        DW_THREE: begin
          if (ADDR64) dat_q <= cfg_wdata[15:0];
        end
        DW_MASK: mask_q <= cfg_wdata[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl = {8'h00, ADDR64, mme_q, MMC_W, en_q};

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      DW_HDR:   rd_mux = {ctrl, NEXT_PTR, CAP_ID};
      DW_ALO:   rd_mux = {alo_q, 2'b00};
      DW_TWO:   rd_mux = ADDR64 ? ahi_q : {16'h0000, dat_q};
      DW_THREE: rd_mux = ADDR64 ? {16'h0000, dat_q} : 32'h0;
      DW_MASK:  rd_mux = 32'(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign en        = en_q;
  assign mme       = mme_q;
  assign base_addr = {ahi_q, alo_q, 2'b00};
  assign base_data = dat_q;
  assign mask      = mask_q;
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               en,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               take,
  output logic               grant_vld,
  output logic [IDX_W-1:0]   grant_idx
);
  logic [NUM_SRC-1:0] irq_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] clr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign rise[g] = irq_req[g] & ~irq_q[g];
    assign elig[g] = pend_q[g] & ~mask[g];
    assign clr[g]  = take && (grant_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_req;
      // a fresh edge wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr) | rise;
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) grant_idx = IDX_W'(i);
    end
  end

  assign grant_vld = en && (|elig);
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       mme,
  input  logic [63:0]      base_addr,
  input  logic [15:0]      base_data,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [63:0]      msg_addr,
  output logic [15:0]      msg_data
);
  logic [15:0] vmask;
  msi_msg_t    nxt;
  msi_msg_t    cur_q;
  logic        vld_q;

  assign vmask    = (16'h0001 << mme) - 16'h0001;
  assign nxt.addr = base_addr;
  assign nxt.data = (base_data & ~vmask) | (16'(idx) & vmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cur_q <= '0;
    end else if (issue) begin
      vld_q <= 1'b1;
      cur_q <= nxt;
    end else if (vld_q && msg_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign msg_valid = vld_q;
  assign msg_addr  = cur_q.addr;
  assign msg_data  = cur_q.data;
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen #(
  parameter int         NUM_SRC  = 8,
  parameter int         MMC      = 3,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [15:0]        msg_data
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               ctl_en;
  logic [2:0]         ctl_mme;
  logic [63:0]        base_addr;
  logic [15:0]        base_data;
  logic [NUM_SRC-1:0] ctl_mask;
  logic               grant_vld;
  logic [IDX_W-1:0]   grant_idx;
  logic               issue;

  // one message in flight; next one is chosen after the handshake
  assign issue = grant_vld && !msg_valid;

  msi_cfg_regs #(
    .NUM_SRC(NUM_SRC), .MMC(MMC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .en(ctl_en), .mme(ctl_mme), .base_addr(base_addr),
    .base_data(base_data), .mask(ctl_mask)
  );

  msi_pend_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst), .irq_req(irq_req), .en(ctl_en), .mask(ctl_mask),
    .take(issue), .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  msi_msg_out #(.IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .issue(issue), .idx(grant_idx), .mme(ctl_mme),
    .base_addr(base_addr), .base_data(base_data), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk #(
  parameter int MMC = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_rd,
  input logic [2:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [15:0] msg_data,
  input logic        en_i,
  input logic [2:0]  mme_i
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[1:0] == 2'b00));

  a_r6_no_send_disabled: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(en_i));

  a_r1_header_fields: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == 3'd0) |=> (cfg_rdata[7:0] == 8'h05 && cfg_rdata[31:24] == 8'h00));

  a_r2_mme_capped: assert property (@(posedge clk) disable iff (rst)
    mme_i <= 3'(MMC));
endmodule

bind msi_msg_gen msi_msg_gen_chk #(.MMC(MMC)) u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .en_i(ctl_en), .mme_i(ctl_mme)
);

// File: tb/msi_msg_gen_bench.sv
`timescale 1ns/1ps
module msi_msg_gen_bench;
  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NSRC-1:0] irq_req = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;

  int n_cmp = 0, n_bad = 0, n_seen = 0, n_exp = 0;
  logic [79:0] sb_q[$];

  // model of the programmed state
  logic [63:0] m_addr = '0;
  logic [15:0] m_data = '0;
  int          m_mme  = 0;

  always #4 clk = ~clk;

  msi_msg_gen u_msi_msg_gen (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [79:0] got, input logic [79:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; cfg_rd = 1'b1;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] bits);
    irq_req = bits;
    @(posedge clk); #1;
    irq_req = '0;
    @(posedge clk); #1;
  endtask

  // driver: expected message for source i
  task automatic expect_msg(input int i);
    logic [15:0] vm;
    vm = 16'((1 << m_mme) - 1);
    sb_q.push_back({m_addr, (m_data & ~vm) | (16'(i) & vm)});
    n_exp++;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 200 && (sb_q.size() != 0 || msg_valid); k++) begin
      @(posedge clk); #1;
    end
    repeat (6) @(posedge clk);
    #1;
    check({tag, " messages seen"}, 80'(n_seen), 80'(n_exp));
  endtask

  task automatic set_ctrl(input bit en, input int mme);
    cfg_write(3'd0, {9'd0, 3'(mme), 3'd0, en, 16'h0000});
    m_mme = mme;
  endtask

  // monitor: pop and compare on each handshake
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      n_seen++;
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected message actual=%h expected=none", {msg_addr, msg_data});
      end else begin
        check("R5/R8 message", {msg_addr, msg_data}, sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;

    // R10 reset state
    check("R10 valid after reset", 80'(msg_valid), 80'(0));
    cfg_read(3'd0, rd); check("R1 R10 header", 80'(rd), 80'(32'h0086_4005));
    cfg_read(3'd1, rd); check("R10 addr lo", 80'(rd), 80'(0));
    cfg_read(3'd3, rd); check("R10 data", 80'(rd), 80'(0));
    cfg_read(3'd4, rd); check("R10 mask", 80'(rd), 80'(0));

    // R2 only enable/MME writable, MME capped at MMC=3
    cfg_write(3'd0, 32'hFFFF_FFFF);
    cfg_read(3'd0, rd); check("R2 header after all-ones", 80'(rd), 80'(32'h00B7_4005));

    // R3 address and data layout
    cfg_write(3'd1, 32'hFEE0_1003);
    cfg_read(3'd1, rd); check("R3 addr lo", 80'(rd), 80'(32'hFEE0_1000));
    cfg_write(3'd2, 32'h0000_0001);
    cfg_read(3'd2, rd); check("R3 addr hi", 80'(rd), 80'(32'h0000_0001));
    cfg_write(3'd3, 32'hABCD_4031);
    cfg_read(3'd3, rd); check("R3 data", 80'(rd), 80'(32'h0000_4031));
    m_addr = 64'h0000_0001_FEE0_1000;
    m_data = 16'h4031;

    // R4 mask width
    cfg_write(3'd4, 32'hFFFF_FF00);
    cfg_read(3'd4, rd); check("R4 mask upper bits", 80'(rd), 80'(0));

    // R5 single source, several grants
    set_ctrl(1'b1, 2);
    expect_msg(5); pulse(8'h20); drain("R5 mme2");
    set_ctrl(1'b1, 0);
    expect_msg(6); pulse(8'h40); drain("R5 mme0");
    set_ctrl(1'b1, 3);
    expect_msg(7); pulse(8'h80); drain("R5 mme3");
    set_ctrl(1'b1, 1);

    // R8 and R9: three at once, stalled consumer
    msg_ready = 1'b0;
    expect_msg(2); expect_msg(4); expect_msg(6);
    pulse(8'h54);
    repeat (5) @(posedge clk);
    #1;
    check("R9 held while stalled", {79'(msg_data), msg_valid}, {79'(sb_q[0][15:0]), 1'b1});
    msg_ready = 1'b1;
    drain("R8 order");

    // R6 mask holds pending, unmask releases
    cfg_write(3'd4, 32'h0000_0008);
    pulse(8'h08);
    repeat (10) @(posedge clk);
    #1;
    check("R6 masked no message", 80'(n_seen), 80'(n_exp));
    expect_msg(3);
    cfg_write(3'd4, 32'h0);
    drain("R6 unmask");

    // R6 disabled holds pending
    set_ctrl(1'b0, 1);
    pulse(8'h02);
    repeat (10) @(posedge clk);
    #1;
    check("R6 disabled no message", 80'(n_seen), 80'(n_exp));
    expect_msg(1);
    set_ctrl(1'b1, 1);
    drain("R6 enable");

    // R7 coalescing of repeated edges
    cfg_write(3'd4, 32'h0000_0001);
    pulse(8'h01); pulse(8'h01); pulse(8'h01);
    expect_msg(0);
    cfg_write(3'd4, 32'h0);
    drain("R7 coalesce");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule